// File: doc/BRIEF.md
# Timing Reference Source Selector

This block picks one of four 8 kHz timing sources and drives the winner as a reference output that an external phase-locked loop locks to. Two of the sources are pulse-type pins: one comes from outside the chip, the other is a secondary frame line taken from the TDM bus. The third source is a free-running clock made by dividing one of two fast clocks. The fourth is a recovered clock made by dividing the system clock with an integer-plus-fraction ratio.

All logic runs on one fast system clock. The pins and fast clocks are treated as asynchronous levels and are synchronized before use. Each pulse pin can be reshaped into a square wave before the selector, because some loops need a 50 % duty reference. A change of selection waits for a rising edge of the new source, so that no short pulse reaches the loop. The output is driven at all times, whatever timing role the chip has.

Top module: `timing_ref_mux`

## Requirements
- R1: While reset is asserted and after it is released with idle inputs, `ref_out` is 0 and the active source is the external pin (code 0).
- R2: Source codes on `src_sel` are 0 external pin, 1 bus line, 2 free-run divider, 3 recovered divider. With squaring off, a level change on the selected pin appears on `ref_out` after exactly three rising edges of `clk`, with its width kept.
- R3: With `sq_ext_en` set, every rising edge of the external pin after the first one since the enable was set drives the squared signal high for floor(P/2) system cycles, where P is the number of cycles between that rising edge and the one before it. The first rising edge after enabling gives no output.
- R4: `sq_sec_en` applies the same squaring to the bus line, independently of the external pin.
- R5: The free-run output toggles on every N-th rising edge of the chosen fast clock, where N is `free_div` (0 and 1 both give a toggle on every edge). `free_src_b` at 0 selects `fast_a` and at 1 selects `fast_b`.
- R6: The recovered output toggles after I + c system cycles, where I is `rec_int` (0 is taken as 1) and c is the carry of an accumulator that adds `rec_frac` modulo 2^RFRAC_W at each toggle. A full period is 2I+1 cycles when `rec_frac` is half the modulus.
- R7: A new value on `src_sel` takes effect only on the next rising edge of the newly selected source. Until then the previous source keeps driving `ref_out`.
- R8: Pins and fast clocks pass through a two-stage synchronizer before any edge is detected (the SYNC_STAGES parameter sets the depth).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_ext | input | 1 | External 8 kHz pulse pin |
| pin_sec | input | 1 | Secondary 8 kHz bus line |
| fast_a | input | 1 | First fast clock for the free-run divider |
| fast_b | input | 1 | Second fast clock for the free-run divider |
| src_sel | input | 2 | Requested source code |
| sq_ext_en | input | 1 | Square the external pin |
| sq_sec_en | input | 1 | Square the bus line |
| free_src_b | input | 1 | Free-run clock choice (0 fast_a, 1 fast_b) |
| free_div | input | FDIV_W | Free-run divide count |
| rec_int | input | RINT_W | Recovered half-period, integer part |
| rec_frac | input | RFRAC_W | Recovered half-period, fractional part |
| ref_out | output | 1 | Selected reference |

## Verification
A wrong period count or a wrong squaring counter shows up as a high time of the wrong length. This is visible on `ref_out` within one input period after the second pulse. A stuck or corrupted divider counter gives a wrong run length on the first full cycle after selection, and a wrong fractional carry shows up as a rising-to-rising period that is off by one cycle. Selection state that switches too early shows up within a few cycles as `ref_out` dropping while the old source is still high.

// File: rtl/tref_pkg.sv
package tref_pkg;
   typedef enum logic [1:0] {
      SRC_EXT  = 2'd0,
      SRC_SEC  = 2'd1,
      SRC_FREE = 2'd2,
      SRC_REC  = 2'd3
   } tref_src_e;
endpackage

// File: rtl/tref_sync.sv
module tref_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl
);
   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign lvl = sh[STAGES-1];
endmodule

// File: rtl/tref_squarer.sv
module tref_squarer #(
   parameter int CW = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic lvl,
   output logic sq
);
   logic [CW-1:0] pcnt;
   logic [CW-1:0] hcnt;
   logic          seen;
   logic          prev;
   logic          rise;

   assign rise = lvl & ~prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
         hcnt <= '0;
         seen <= 1'b0;
         prev <= 1'b0;
      end else begin
         prev <= lvl;
         if (rise)              pcnt <= CW'(1);
         else if (pcnt != '1)   pcnt <= pcnt + 1'b1;
         if (!en) begin
            seen <= 1'b0;
            hcnt <= '0;
         end else if (rise) begin
            seen <= 1'b1;
            hcnt <= seen ? (pcnt >> 1) : '0;
         end else if (hcnt != '0) begin
            hcnt <= hcnt - 1'b1;
         end
      end
   end

   assign sq = en ? (hcnt != '0) : lvl;
endmodule

// File: rtl/tref_free_div.sv
module tref_free_div #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic [DW-1:0] div,
   output logic          lvl
);
   logic [DW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         lvl <= 1'b0;
      end else if (step) begin
         if (({1'b0, cnt} + 1'b1) >= {1'b0, div}) begin
            cnt <= '0;
            lvl <= ~lvl;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tref_rec_div.sv
module tref_rec_div #(
   parameter int IW = 12,
   parameter int FW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] int_div,
   input  logic [FW-1:0] frac_div,
   output logic          lvl,
   output logic          wrap
);
   logic [IW-1:0] cnt;
   logic [FW-1:0] acc;
   logic [FW:0]   sum;
   logic [IW-1:0] ieff;

   assign sum  = {1'b0, acc} + {1'b0, frac_div};
   assign ieff = (int_div == '0) ? IW'(1) : int_div;
   assign wrap = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         acc <= '0;
         lvl <= 1'b0;
      end else if (wrap) begin
         lvl <= ~lvl;
         acc <= sum[FW-1:0];
         cnt <= ieff - 1'b1 + {{(IW-1){1'b0}}, sum[FW]};
      end else begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/timing_ref_mux.sv
module timing_ref_mux
   import tref_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PER_W       = 16,
   parameter int FDIV_W      = 16,
   parameter int RINT_W      = 12,
   parameter int RFRAC_W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pin_ext,
   input  logic               pin_sec,
   input  logic               fast_a,
   input  logic               fast_b,
   input  logic [1:0]         src_sel,
   input  logic               sq_ext_en,
   input  logic               sq_sec_en,
   input  logic               free_src_b,
   input  logic [FDIV_W-1:0]  free_div,
   input  logic [RINT_W-1:0]  rec_int,
   input  logic [RFRAC_W-1:0] rec_frac,
   output logic               ref_out
);
   localparam int NPIN = 2;
   localparam int NSRC = 4;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PER_W < 4) begin : g_bad_per
      $error("PER_W too small");
   end
   if (RFRAC_W < 1 || RINT_W < 1 || FDIV_W < 1) begin : g_bad_div
      $error("divider widths must be positive");
   end

   logic [NPIN-1:0] pin_raw, pin_lvl, pin_src, sq_en;
   logic [1:0]      fast_raw, fast_lvl, fast_prev, fast_rise;
   logic            free_step, free_lvl, rec_lvl, rec_wrap;
   logic [NSRC-1:0] src_now, src_prev;
   logic            cand_rise, take;
   tref_src_e       act;
   logic [1:0]      sel_eff;

   assign pin_raw  = {pin_sec, pin_ext};
   assign sq_en    = {sq_sec_en, sq_ext_en};
   assign fast_raw = {fast_b, fast_a};

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      tref_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .d(pin_raw[i]), .lvl(pin_lvl[i]));
      tref_squarer #(.CW(PER_W)) u_sq (
         .clk(clk), .rst_n(rst_n), .en(sq_en[i]), .lvl(pin_lvl[i]), .sq(pin_src[i]));
   end

   for (genvar j = 0; j < 2; j++) begin : g_fast
      tref_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .d(fast_raw[j]), .lvl(fast_lvl[j]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fast_prev <= '0;
      else        fast_prev <= fast_lvl;
   end

   assign fast_rise = fast_lvl & ~fast_prev;
   assign free_step = free_src_b ? fast_rise[1] : fast_rise[0];

   tref_free_div #(.DW(FDIV_W)) u_free (
      .clk(clk), .rst_n(rst_n), .step(free_step), .div(free_div), .lvl(free_lvl));

   tref_rec_div #(.IW(RINT_W), .FW(RFRAC_W)) u_rec (
      .clk(clk), .rst_n(rst_n), .int_div(rec_int), .frac_div(rec_frac),
      .lvl(rec_lvl), .wrap(rec_wrap));

   assign src_now   = {rec_lvl, free_lvl, pin_src[1], pin_src[0]};
   assign cand_rise = src_now[src_sel] & ~src_prev[src_sel];
   assign take      = (src_sel != act) && cand_rise;
   assign sel_eff   = take ? src_sel : act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_prev <= '0;
         act      <= SRC_EXT;
         ref_out  <= 1'b0;
      end else begin
         src_prev <= src_now;
         if (take) act <= tref_src_e'(src_sel);
         ref_out  <= src_now[sel_eff];
      end
   end
endmodule

// File: rtl/tref_chk.sv
module tref_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] sel_req,
   input logic [1:0] act,
   input logic       cand_rise,
   input logic       free_lvl,
   input logic       free_step,
   input logic       rec_lvl,
   input logic       rec_wrap,
   input logic       sq_en0,
   input logic       pin_lvl0,
   input logic       pin_src0
);
   a_r7_switch_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (act != $past(act)) |-> $past(cand_rise));

   a_r7_switch_to_request: assert property (@(posedge clk) disable iff (!rst_n)
      (act != $past(act)) |-> (act == $past(sel_req)));

   a_r5_free_only_on_step: assert property (@(posedge clk) disable iff (!rst_n)
      (free_lvl != $past(free_lvl)) |-> $past(free_step));

   a_r6_rec_only_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_lvl != $past(rec_lvl)) |-> $past(rec_wrap));

   a_r3_square_follows_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_en0 && $past(sq_en0) && $rose(pin_src0)) |-> ($past(pin_lvl0) && !$past(pin_lvl0, 2)));
endmodule

bind timing_ref_mux tref_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sel_req(src_sel), .act(act), .cand_rise(cand_rise),
   .free_lvl(free_lvl), .free_step(free_step), .rec_lvl(rec_lvl), .rec_wrap(rec_wrap),
   .sq_en0(sq_ext_en), .pin_lvl0(pin_lvl[0]), .pin_src0(pin_src[0]));

// File: tb/tb_timing_ref_mux.sv
`timescale 1ns/1ps
module tb_timing_ref_mux;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_ext = 1'b0, pin_sec = 1'b0, fast_a = 1'b0, fast_b = 1'b0;
   logic [1:0]  src_sel = 2'd0;
   logic        sq_ext_en = 1'b0, sq_sec_en = 1'b0, free_src_b = 1'b0;
   logic [15:0] free_div = 16'd5;
   logic [11:0] rec_int = 12'd10;
   logic [7:0]  rec_frac = 8'd0;
   logic        ref_out;

   int checks = 0, errors = 0;

   typedef struct { int len; string tag; } exp_t;
   exp_t exp_q[$];
   bit   mon_arm = 0, mon_on = 0;
   bit   prev_out = 0;
   int   run = 0;

   always #2 clk = ~clk;

   timing_ref_mux dut (
      .clk(clk), .rst_n(rst_n), .pin_ext(pin_ext), .pin_sec(pin_sec),
      .fast_a(fast_a), .fast_b(fast_b), .src_sel(src_sel),
      .sq_ext_en(sq_ext_en), .sq_sec_en(sq_sec_en), .free_src_b(free_src_b),
      .free_div(free_div), .rec_int(rec_int), .rec_frac(rec_frac), .ref_out(ref_out));

   // fast clocks: a toggles every cycle, b every third cycle
   initial begin
      int k;
      k = 0;
      forever begin
         @(negedge clk);
         fast_a = ~fast_a;
         k++;
         if (k == 3) begin fast_b = ~fast_b; k = 0; end
      end
   end

   task automatic check(bit ok, string tag, int act_v, int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
      end
   endtask

   // monitor: measures each high run of ref_out and pops the scoreboard
   always @(negedge clk) begin
      if (ref_out && !prev_out) run = 1;
      else if (ref_out)         run++;
      if (!ref_out && prev_out && mon_on && exp_q.size() != 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check(run == e.len, e.tag, run, e.len);
         if (exp_q.size() == 0) begin mon_on = 0; mon_arm = 0; end
      end
      if (ref_out && !prev_out && mon_arm) mon_on = 1;
      prev_out = ref_out;
   end

   task automatic expect_runs(int n, int len, string tag);
      for (int i = 0; i < n; i++) exp_q.push_back('{len, tag});
      mon_arm = 1;
   endtask

   task automatic drain(string tag, int maxc);
      int k;
      k = 0;
      while (exp_q.size() != 0 && k < maxc) begin @(negedge clk); k++; end
      check(exp_q.size() == 0, tag, exp_q.size(), 0);
      exp_q.delete();
      mon_arm = 0;
      mon_on = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_ext(int width, int period);
      pin_ext = 1'b1; idle(width); pin_ext = 1'b0; idle(period - width);
   endtask

   task automatic pulse_sec(int width, int period);
      pin_sec = 1'b1; idle(width); pin_sec = 1'b0; idle(period - width);
   endtask

   task automatic rise_to_rise(output int cyc);
      bit p;
      p = ref_out;
      do begin @(negedge clk); if (ref_out && !p) break; p = ref_out; end while (1);
      cyc = 0;
      p = ref_out;
      do begin @(negedge clk); cyc++; if (ref_out && !p) break; p = ref_out; end while (cyc < 1000);
   endtask

   initial begin
      int per;
      idle(3);
      check(ref_out == 1'b0, "R1 out low in reset", ref_out, 0);
      rst_n = 1'b1;
      idle(10);
      check(ref_out == 1'b0, "R1 out low after reset", ref_out, 0);

      // R2 / R8: three-edge latency through synchronizer and output register
      pin_ext = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check(ref_out == 1'b0, "R8 not yet after two edges", ref_out, 0);
      @(posedge clk); @(negedge clk);
      check(ref_out == 1'b1, "R2 visible after three edges", ref_out, 1);
      idle(4); pin_ext = 1'b0; idle(10);

      // R2: pass-through keeps pulse width
      expect_runs(4, 3, "R2 pass-through width");
      for (int i = 0; i < 4; i++) pulse_ext(3, 20);
      drain("R2 drain", 50);

      // R3: squaring of external pin, period 40 -> high 20, first pulse silent
      sq_ext_en = 1'b1; idle(5);
      expect_runs(5, 20, "R3 squared ext");
      for (int i = 0; i < 6; i++) pulse_ext(2, 40);
      drain("R3 drain", 100);

      // R7: deferred switch; old source keeps driving
      sq_ext_en = 1'b0; pin_ext = 1'b1; idle(10);
      check(ref_out == 1'b1, "R2 ext level high", ref_out, 1);
      src_sel = 2'd1; sq_sec_en = 1'b1; idle(50);
      check(ref_out == 1'b1, "R7 held by old source", ref_out, 1);
      pin_ext = 1'b0; idle(10);
      check(ref_out == 1'b0, "R7 still old source", ref_out, 0);

      // R4: squaring of bus line, period 60 -> high 30
      expect_runs(5, 30, "R4 squared sec");
      for (int i = 0; i < 6; i++) pulse_sec(1, 60);
      drain("R4 drain", 100);

      // R5: free-run divider
      src_sel = 2'd2; free_src_b = 1'b0; free_div = 16'd5; idle(40);
      expect_runs(4, 10, "R5 free a div5");
      drain("R5 drain a", 200);
      free_src_b = 1'b1; free_div = 16'd3; idle(60);
      expect_runs(3, 18, "R5 free b div3");
      drain("R5 drain b", 300);
      free_src_b = 1'b0; free_div = 16'd0; idle(20);
      expect_runs(3, 2, "R5 free div0");
      drain("R5 drain div0", 50);

      // R6: recovered divider
      src_sel = 2'd3; rec_int = 12'd10; rec_frac = 8'd0; idle(40);
      expect_runs(4, 10, "R6 rec int10");
      drain("R6 drain int10", 200);
      rec_int = 12'd0; idle(10);
      expect_runs(3, 1, "R6 rec int0");
      drain("R6 drain int0", 50);
      rec_int = 12'd10; rec_frac = 8'd128; idle(60);
      for (int i = 0; i < 3; i++) begin
         rise_to_rise(per);
         check(per == 21, "R6 fractional period", per, 21);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule